// File: doc/BRIEF.md
# PCI Bus Stall and Write-Parity Monitor

This block sits beside the central arbiter of a conventional 32-bit PCI bus and watches the sampled active-low control lines. It runs three cycle counters. The first catches a granted master that never starts its cycle. The second catches a target that neither accepts nor refuses a data phase, and its limit depends on whether the phase is the first of the transaction or a later one. The third catches a master that never signals it is ready. A fourth detector flags a reported parity error on write data when another device owns the bus.

Each detector sets its own sticky bit in a 32-bit status word. Software clears a bit by writing a one to it. A separate enable word selects which set bits drive the single interrupt request. The status word and the interrupt request are both registered, and they change on the same clock edge.

Top module: `pci_stall_monitor`

## Requirements
- R1: After `rst` or a one-cycle `sw_rst`, `status` reads 0x00000000 and `irq` is 0. `sw_rst` does not change the enable word.
- R2: While any `gnt` bit is high and the bus is idle (`frame_n` and `irdy_n` both high), bit 13 sets on the 16th consecutive such clock, and not on the 15th. A change of the `gnt` vector restarts the count.
- R3: In the first data phase of a transaction (bus busy, i.e. `frame_n` or `irdy_n` low), bit 12 sets on the 16th consecutive clock on which `trdy_n` and `stop_n` are both high.
- R4: A data phase ends on a busy clock where `irdy_n` and `trdy_n` are both low, or where `stop_n` is low. Every later phase sets bit 12 on the 8th consecutive clock with `trdy_n` and `stop_n` high.
- R5: While the bus is busy, bit 11 sets on the 8th consecutive clock with `irdy_n` high.
- R6: Bit 1 sets after a busy clock with `perr_n` low, `wr_cycle` high and `local_master` low. With `local_master` high or `wr_cycle` low, that clock has no effect on `status`.
- R7: A counter that reaches its limit holds there, so a stall that goes on sets its bit only once. A clock with `frame_n` and `irdy_n` both high ends the transaction, clears the counters and returns the phase tracking to the first phase.
- R8: With `clr_we` high, each one in `clr_data` clears the matching `status` bit. A bit that is set and cleared in the same clock stays set.
- R9: `irq` equals the OR over all bits of `status` AND enable word. The enable word loads `mask_data` when `mask_we` is high and resets to 0.
- R10: All `status` bits other than 13, 12, 11 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sw_rst | input | 1 | Synchronous software reset of status and counters |
| gnt | input | NUM_MASTERS | Current grant vector, active high |
| local_master | input | 1 | High when the local controller owns the bus |
| wr_cycle | input | 1 | High when the current transaction writes data |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| trdy_n | input | 1 | Sampled TRDY#, active low |
| stop_n | input | 1 | Sampled STOP#, active low |
| perr_n | input | 1 | Sampled PERR#, active low |
| clr_we | input | 1 | Write strobe for write-one-to-clear |
| clr_data | input | DATA_W | Bits to clear |
| mask_we | input | 1 | Write strobe for the enable word |
| mask_data | input | DATA_W | New enable word |
| status | output | DATA_W | Sticky interrupt status |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
A detector can set a bit on the same clock that software writes a one to clear that bit. The same is true of an enable-word write and a new set. The bench provokes the first case on purpose. It holds `perr_n` low on a foreign write while `clr_we` targets bit 1, and it expects the bit to survive. In a seeded random stretch, parity events, clear writes and enable writes coincide freely. A bench model there applies clear first, then set, then recomputes the interrupt from the updated status and enable word, and compares both outputs every clock.

// File: rtl/pci_mon_pkg.sv
package pci_mon_pkg;
  localparam int BIT_MST_BROKEN = 13;
  localparam int BIT_TGT_TMO    = 12;
  localparam int BIT_MST_TMO    = 11;
  localparam int BIT_WR_PERR    = 1;

  localparam logic [31:0] IMPL_BITS = (32'd1 << BIT_MST_BROKEN) | (32'd1 << BIT_TGT_TMO)
                                    | (32'd1 << BIT_MST_TMO)    | (32'd1 << BIT_WR_PERR);

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pci_mon_stall_cnt.sv
module pci_mon_stall_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (restart)
      cnt <= run ? CNT_W'(1) : '0;
    else if (run && (cnt < limit))
      cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    if (!run || clear)
      hit = 1'b0;
    else if (restart)
      hit = (limit == CNT_W'(1));
    else
      hit = (cnt == limit - CNT_W'(1));
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= limit) // R7
    else $error("stall counter passed its limit");
  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (rst) (hit && !restart) |=> !hit) // R7
    else $error("stall counter fired twice in a row");
endmodule

// File: rtl/pci_mon_phase.sv
module pci_mon_phase (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic phase_end,
  output logic later_phase
);
  always_ff @(posedge clk) begin
    if (rst || !busy)
      later_phase <= 1'b0;
    else if (phase_end)
      later_phase <= 1'b1;
  end

  AST_LATER_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) later_phase |-> $past(busy)) // R4
    else $error("later phase outside a transaction");
  AST_IDLE_RESETS: assert property (@(posedge clk) disable iff (rst) !busy |=> !later_phase) // R7
    else $error("phase tracker not reset at transaction end");
endmodule

// File: rtl/pci_mon_status.sv
module pci_mon_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] clr_eff;

  always_comb begin
    clr_eff  = clr_we ? clr_data : '0;
    status_d = (status & ~clr_eff) | set_vec;
    mask_d   = mask_we ? mask_data : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (sw_rst) begin
        status <= '0;
        irq    <= 1'b0;
      end else begin
        status <= status_d;
        irq    <= |(status_d & mask_d);
      end
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))) // R8
    else $error("set event lost");
  AST_CLR_W1C: assert property (@(posedge clk) disable iff (rst || sw_rst)
    clr_we |=> ((status & $past(clr_data & ~set_vec)) == '0)) // R8
    else $error("write-one-to-clear failed");
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status & mask_q))) // R9
    else $error("irq out of step with status and mask");
endmodule

// File: rtl/pci_stall_monitor.sv
module pci_stall_monitor
  import pci_mon_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int NUM_MASTERS     = 4,
  parameter int GNT_LIMIT       = 16,
  parameter int TGT_FIRST_LIMIT = 16,
  parameter int TGT_LATER_LIMIT = 8,
  parameter int IRDY_LIMIT      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sw_rst,
  input  logic [NUM_MASTERS-1:0] gnt,
  input  logic                   local_master,
  input  logic                   wr_cycle,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  input  logic                   trdy_n,
  input  logic                   stop_n,
  input  logic                   perr_n,
  input  logic                   clr_we,
  input  logic [DATA_W-1:0]      clr_data,
  input  logic                   mask_we,
  input  logic [DATA_W-1:0]      mask_data,
  output logic [DATA_W-1:0]      status,
  output logic                   irq
);
  localparam int CNT_W = $clog2(max_of3(GNT_LIMIT, TGT_FIRST_LIMIT, IRDY_LIMIT) + 1);
  localparam logic [CNT_W-1:0] LIM_GNT   = CNT_W'(GNT_LIMIT);
  localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(TGT_FIRST_LIMIT);
  localparam logic [CNT_W-1:0] LIM_LATER = CNT_W'(TGT_LATER_LIMIT);
  localparam logic [CNT_W-1:0] LIM_IRDY  = CNT_W'(IRDY_LIMIT);

  logic sclr;
  logic busy;
  logic phase_end;
  logic later_phase;
  logic gnt_any;
  logic gnt_changed;
  logic [NUM_MASTERS-1:0] gnt_q;
  logic hit_gnt, hit_tgt, hit_irdy, hit_perr;
  logic [CNT_W-1:0] tgt_limit;
  logic [DATA_W-1:0] set_vec;

  always_comb begin
    sclr        = rst || sw_rst;
    busy        = !frame_n || !irdy_n;
    phase_end   = busy && ((!irdy_n && !trdy_n) || !stop_n);
    gnt_any     = |gnt;
    gnt_changed = (gnt != gnt_q);
    tgt_limit   = later_phase ? LIM_LATER : LIM_FIRST;
    hit_perr    = busy && wr_cycle && !local_master && !perr_n;
  end

  always_ff @(posedge clk) begin
    if (sclr) gnt_q <= '0;
    else      gnt_q <= gnt;
  end

  pci_mon_phase u_phase (
    .clk(clk), .rst(sclr), .busy(busy), .phase_end(phase_end), .later_phase(later_phase)
  );

  pci_mon_stall_cnt #(.CNT_W(CNT_W)) u_gnt_cnt (
    .clk(clk), .rst(sclr), .clear(!gnt_any || busy), .restart(gnt_changed),
    .run(gnt_any && !busy), .limit(LIM_GNT), .hit(hit_gnt)
  );

  pci_mon_stall_cnt #(.CNT_W(CNT_W)) u_tgt_cnt (
    .clk(clk), .rst(sclr), .clear(!busy || !trdy_n || !stop_n), .restart(1'b0),
    .run(busy && trdy_n && stop_n), .limit(tgt_limit), .hit(hit_tgt)
  );

  pci_mon_stall_cnt #(.CNT_W(CNT_W)) u_irdy_cnt (
    .clk(clk), .rst(sclr), .clear(!busy || !irdy_n), .restart(1'b0),
    .run(busy && irdy_n), .limit(LIM_IRDY), .hit(hit_irdy)
  );

  always_comb begin
    set_vec                 = '0;
    set_vec[BIT_MST_BROKEN] = hit_gnt;
    set_vec[BIT_TGT_TMO]    = hit_tgt;
    set_vec[BIT_MST_TMO]    = hit_irdy;
    set_vec[BIT_WR_PERR]    = hit_perr;
  end

  pci_mon_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .set_vec(set_vec),
    .clr_we(clr_we), .clr_data(clr_data), .mask_we(mask_we), .mask_data(mask_data),
    .status(status), .irq(irq)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status & ~DATA_W'(IMPL_BITS)) == '0) // R10
    else $error("reserved status bit set");
  AST_PERR_SRC: assert property (@(posedge clk) disable iff (sclr)
    $rose(status[BIT_WR_PERR]) |-> $past(!perr_n && !local_master && wr_cycle)) // R6
    else $error("parity bit set without a foreign write error");
  AST_MB_NEEDS_GNT: assert property (@(posedge clk) disable iff (sclr)
    $rose(status[BIT_MST_BROKEN]) |-> $past(gnt_any && frame_n)) // R2
    else $error("master-broken bit set without a grant");
  AST_MT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (sclr)
    $rose(status[BIT_MST_TMO]) |-> $past(busy && irdy_n)) // R5
    else $error("master-timeout bit set outside a stall");
endmodule

// File: tb/test_pci_stall_monitor.sv
module test_pci_stall_monitor;
  localparam int NM = 4;
  localparam logic [31:0] B13 = 32'd1 << 13;
  localparam logic [31:0] B12 = 32'd1 << 12;
  localparam logic [31:0] B11 = 32'd1 << 11;
  localparam logic [31:0] B1  = 32'd1 << 1;

  logic clk = 1'b0;
  logic rst, sw_rst, local_master, wr_cycle;
  logic frame_n, irdy_n, trdy_n, stop_n, perr_n;
  logic [NM-1:0] gnt;
  logic clr_we, mask_we;
  logic [31:0] clr_data, mask_data;
  logic [31:0] status;
  logic irq;

  int runs = 0;
  int fails = 0;
  logic [31:0] m_status, m_mask;

  always #10 clk = ~clk;

  pci_stall_monitor #(.NUM_MASTERS(NM)) i_pci_stall_monitor (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .gnt(gnt), .local_master(local_master),
    .wr_cycle(wr_cycle), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .perr_n(perr_n), .clr_we(clr_we), .clr_data(clr_data),
    .mask_we(mask_we), .mask_data(mask_data), .status(status), .irq(irq)
  );

  function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] mk);
    return |(st & mk);
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] st, input logic cw,
                                           input logic [31:0] cd, input logic [31:0] setv);
    return (st & ~(cw ? cd : 32'd0)) | setv;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    runs++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic clear_bits(input logic [31:0] bits);
    clr_we = 1'b1; clr_data = bits;
    tick(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic go_idle();
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; perr_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; sw_rst = 1'b0; gnt = '0; local_master = 1'b0; wr_cycle = 1'b0;
    go_idle();
    clr_we = 1'b0; clr_data = '0; mask_we = 1'b0; mask_data = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 reset status", status, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    mask_we = 1'b1; mask_data = 32'hFFFF_FFFF; tick(1); mask_we = 1'b0;

    // R2 grant without FRAME
    gnt = 4'b0010;
    tick(15);
    chk("R2 no set at 15", status, 32'd0);
    tick(1);
    chk("R2 set at 16", status, B13);
    chk("R9 irq with status", {31'd0, irq}, 32'd1);
    clear_bits(B13);
    tick(10);
    chk("R7 saturated grant counter", status, 32'd0);
    gnt = 4'b0100;
    tick(15);
    chk("R2 restart on grant change", status, 32'd0);
    tick(1);
    chk("R2 set after restart", status, B13);
    gnt = '0;
    clear_bits(B13);

    // R3 first-phase target limit
    frame_n = 1'b0; irdy_n = 1'b0;
    tick(15);
    chk("R3 no set at 15", status, 32'd0);
    tick(1);
    chk("R3 set at 16", status, B12);
    // R4 end phase with IRDY/TRDY
    clr_we = 1'b1; clr_data = B12; trdy_n = 1'b0; tick(1);
    clr_we = 1'b0; trdy_n = 1'b1;
    tick(7);
    chk("R4 later no set at 7", status, 32'd0);
    tick(1);
    chk("R4 later set at 8", status, B12);
    // R4 end phase with STOP
    clr_we = 1'b1; clr_data = B12; stop_n = 1'b0; tick(1);
    clr_we = 1'b0; stop_n = 1'b1;
    tick(7);
    chk("R4 stop later no set at 7", status, 32'd0);
    tick(1);
    chk("R4 stop later set at 8", status, B12);
    // R7 transaction end returns to first phase
    clr_we = 1'b1; clr_data = B12; frame_n = 1'b1; irdy_n = 1'b1; tick(1);
    clr_we = 1'b0; frame_n = 1'b0; irdy_n = 1'b0;
    tick(8);
    chk("R7 first phase again at 8", status, 32'd0);
    tick(8);
    chk("R7 first phase set at 16", status, B12);
    go_idle();
    clear_bits(B12);

    // R5 IRDY stall
    frame_n = 1'b0;
    tick(7);
    chk("R5 no set at 7", status, 32'd0);
    tick(1);
    chk("R5 set at 8", status, B11);
    go_idle();
    clear_bits(32'hFFFF_FFFF);
    chk("R8 clear all", status, 32'd0);

    // R6 write parity
    frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0; wr_cycle = 1'b1;
    perr_n = 1'b0; tick(1); perr_n = 1'b1;
    chk("R6 foreign write parity", status, B1);
    clear_bits(B1);
    local_master = 1'b1; perr_n = 1'b0; tick(1); perr_n = 1'b1;
    chk("R6 ignored when local", status, 32'd0);
    local_master = 1'b0; wr_cycle = 1'b0; perr_n = 1'b0; tick(1); perr_n = 1'b1;
    chk("R6 ignored on read", status, 32'd0);
    wr_cycle = 1'b1;

    // R8 set wins over clear
    perr_n = 1'b0; tick(1);
    clr_we = 1'b1; clr_data = B1; tick(1);
    clr_we = 1'b0; perr_n = 1'b1;
    chk("R8 set wins", status, B1);
    clear_bits(B1);
    chk("R8 clear works", status, 32'd0);

    // R9 mask
    perr_n = 1'b0; tick(1); perr_n = 1'b1;
    mask_we = 1'b1; mask_data = 32'd0; tick(1); mask_we = 1'b0;
    chk("R9 masked irq", {31'd0, irq}, 32'd0);
    chk("R9 status kept", status, B1);
    mask_we = 1'b1; mask_data = B1; tick(1); mask_we = 1'b0;
    chk("R9 enabled irq", {31'd0, irq}, 32'd1);

    // R1 software reset
    sw_rst = 1'b1; tick(1); sw_rst = 1'b0;
    chk("R1 sw reset status", status, 32'd0);
    chk("R1 sw reset irq", {31'd0, irq}, 32'd0);
    perr_n = 1'b0; tick(1); perr_n = 1'b1;
    chk("R1 mask kept after sw reset", {31'd0, irq}, 32'd1);

    // Random: parity events, clears and mask writes collide (R8, R9, R10)
    clear_bits(32'hFFFF_FFFF);
    mask_we = 1'b1; mask_data = 32'hFFFF_FFFF; tick(1); mask_we = 1'b0;
    m_status = '0; m_mask = 32'hFFFF_FFFF;
    for (int it = 0; it < 400; it++) begin
      logic [31:0] setv;
      local_master = 1'($urandom % 2);
      perr_n       = ($urandom % 3) != 0;
      clr_we       = 1'($urandom % 2);
      clr_data     = $urandom;
      mask_we      = ($urandom % 5) == 0;
      mask_data    = $urandom;
      setv = (!perr_n && !local_master) ? B1 : 32'd0;
      tick(1);
      m_status = exp_next(m_status, clr_we, clr_data, setv);
      if (mask_we) m_mask = mask_data;
      chk("R8 random status", status, m_status);
      chk("R9 random irq", {31'd0, irq}, {31'd0, exp_irq(m_status, m_mask)});
      chk("R10 reserved bits", status & ~(B13 | B12 | B11 | B1), 32'd0);
    end
    clr_we = 1'b0; mask_we = 1'b0; perr_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule